// File: doc/BRIEF.md
# Bus Master DMA Channel Register Block

This block holds the software-visible control state of one disk-channel DMA engine: a command byte, a status byte and a descriptor table pointer. It sits behind a word-wide register port with per-byte lane enables. Writes to the command byte that flip the run bit become one-cycle start or abort pulses toward a separate DMA sequencer. A start pulse carries the pointer value that applies at that moment.

The sequencer reports back through two pulse inputs. One says a transfer finished and the other says a transfer failed. The block keeps the running, interrupt and error flags in line with those events and with software accesses, and drives the interrupt flag out as the channel's interrupt line. The register port has two words, selected by a one-bit word index: word 0 is the control word and word 1 is the pointer. A byte offset equals four times the word index plus the lane number.

Top module: `bmdma_regs`

## Requirements
- R1: After reset the command byte reads 0x00, the status byte reads 0x60 (both capability bits set), the pointer reads 0 and the interrupt output is low.
- R2: The command byte is lane 0 of word 0 (offset 0x0), the status byte is lane 2 of word 0 (offset 0x2), and the 32-bit pointer is word 1 (offset 0x4). Lanes 1 and 3 of word 0 read as zero, and writes that enable only those lanes have no effect.
- R3: Command bit 0 is the run bit. A command write that takes it from 0 to 1 sets status bit 0 (active). In the following cycle it raises the start output for exactly one cycle, with the start pointer output equal to the pointer register.
- R4: A command write that takes the run bit from 1 to 0 clears the active bit and raises the abort output for one cycle.
- R5: Command bit 3 is the direction bit. While the run bit is already 1, a command write leaves the direction bit unchanged. Otherwise the write stores it.
- R6: A status write never changes the active bit (status bit 0).
- R7: Status bit 2 (interrupt) and status bit 1 (error) clear when 1 is written to them. Writing 0 leaves them as they were.
- R8: Each enabled byte lane of a pointer write updates that byte, and pointer bits 1:0 always read as zero.
- R9: A completion pulse clears the run bit and the active bit and sets the interrupt bit. The interrupt output follows the interrupt bit. A run-bit edge written in the same cycle as a completion produces no start or abort pulse.
- R10: A failure pulse sets the error bit.
- R11: A word-0 write whose lane enables touch lane 0 or lane 2 but are not exactly 0001 or 0100 raises the access-error output for one cycle and changes no register.
- R12: When a completion arrives in the same cycle as a write of 1 to the interrupt bit, the interrupt bit ends set. The same holds for a failure and a write of 1 to the error bit.
- R13: Status bits 5 and 6 (capability) take the written value on a status write. Status bits 3, 4 and 7 and command bits 1, 2 and 4 to 7 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_word | input | 1 | Word index: 0 control word, 1 pointer |
| reg_be | input | 4 | Byte lane enables for a write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed word, combinational |
| seq_done | input | 1 | Completion pulse from the sequencer |
| seq_fault | input | 1 | Failure pulse from the sequencer |
| dma_start | output | 1 | One-cycle start request |
| dma_start_ptr | output | 32 | Pointer value captured with the start request |
| dma_abort | output | 1 | One-cycle abort request |
| dma_irq | output | 1 | Interrupt flag |
| reg_acc_err | output | 1 | One-cycle access size error |

## Verification
The hardest situations to reach are the ones that depend on prior state. The frozen direction bit only shows when a transfer is already running, and the write-one-to-clear flags only show when they were set beforehand by sequencer events. The bench therefore rebuilds a chosen starting state before every single write. For each of the 256 command values it steps through a stopped and a running state with a known old direction. For each of the 256 status values it steps through all eight combinations of active, interrupt and error, which it produces with start writes, completion pulses and failure pulses. Collisions are driven in one cycle on purpose: completion against interrupt clear, failure against error clear, and completion against start.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    // command byte bit positions
    localparam int CMD_RUN = 0;
    localparam int CMD_DIR = 3;

    // status byte bit positions
    localparam int STS_ACT  = 0;
    localparam int STS_ERR  = 1;
    localparam int STS_INT  = 2;
    localparam int STS_CAP0 = 5;
    localparam int STS_CAP1 = 6;

    // byte lanes inside the control word
    localparam int LANE_CMD = 0;
    localparam int LANE_STS = 2;

    typedef struct packed {
        logic run;
        logic dir;
        logic start_pls;
        logic abort_pls;
    } cmd_state_t;

    typedef struct packed {
        logic       act;
        logic       err;
        logic       intr;
        logic [1:0] cap;
    } sts_state_t;

endpackage

// File: rtl/bmdma_cmd_unit.sv
module bmdma_cmd_unit
    import bmdma_pkg::*;
#(
    parameter int PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [7:0]       wbyte_i,
    input  logic             done_i,
    input  logic [PTR_W-1:0] ptr_i,
    output logic             start_o,
    output logic             abort_o,
    output logic [PTR_W-1:0] start_ptr_o,
    output logic             rise_o,
    output logic             fall_o,
    output logic [7:0]       cmd_byte_o
);

    cmd_state_t       st_d, st_q;
    logic [PTR_W-1:0] snap_d, snap_q;
    logic             rise, fall;
    logic             unused_bits;

    assign unused_bits = ^{wbyte_i[7:4], wbyte_i[2:1]};

    always_comb begin
        st_d           = st_q;
        st_d.start_pls = 1'b0;
        st_d.abort_pls = 1'b0;
        snap_d         = snap_q;
        rise           = 1'b0;
        fall           = 1'b0;
        if (wr_i) begin
            if (!st_q.run) begin
                st_d.dir = wbyte_i[CMD_DIR];
            end
            st_d.run = wbyte_i[CMD_RUN];
            rise     = !st_q.run && wbyte_i[CMD_RUN] && !done_i;
            fall     = st_q.run && !wbyte_i[CMD_RUN] && !done_i;
        end
        if (done_i) begin
            st_d.run = 1'b0;
        end
        st_d.start_pls = rise;
        st_d.abort_pls = fall;
        if (rise) begin
            snap_d = ptr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= '0;
            snap_q <= '0;
        end else begin
            st_q   <= st_d;
            snap_q <= snap_d;
        end
    end

    assign start_o     = st_q.start_pls;
    assign abort_o     = st_q.abort_pls;
    assign start_ptr_o = snap_q;
    assign rise_o      = rise;
    assign fall_o      = fall;
    assign cmd_byte_o  = {4'b0000, st_q.dir, 2'b00, st_q.run};

endmodule

// File: rtl/bmdma_sts_unit.sv
module bmdma_sts_unit
    import bmdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [7:0] wbyte_i,
    input  logic       done_i,
    input  logic       fault_i,
    input  logic       act_set_i,
    input  logic       act_clr_i,
    output logic [7:0] sts_byte_o,
    output logic       irq_o
);

    sts_state_t st_d, st_q;
    logic       unused_bits;

    assign unused_bits = ^{wbyte_i[7], wbyte_i[4:3], wbyte_i[STS_ACT]};

    always_comb begin
        st_d = st_q;
        if (act_set_i) begin
            st_d.act = 1'b1;
        end
        if (act_clr_i) begin
            st_d.act = 1'b0;
        end
        if (wr_i) begin
            if (wbyte_i[STS_INT]) begin
                st_d.intr = 1'b0;
            end
            if (wbyte_i[STS_ERR]) begin
                st_d.err = 1'b0;
            end
            st_d.cap = {wbyte_i[STS_CAP1], wbyte_i[STS_CAP0]};
        end
        if (done_i) begin
            st_d.act  = 1'b0;
            st_d.intr = 1'b1;
        end
        if (fault_i) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cap <= 2'b11;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts_byte_o = {1'b0, st_q.cap[1], st_q.cap[0], 2'b00,
                         st_q.intr, st_q.err, st_q.act};
    assign irq_o      = st_q.intr;

endmodule

// File: rtl/bmdma_ptr_unit.sv
module bmdma_ptr_unit #(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [DATA_W/8-1:0] be_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   ptr_o
);

    localparam int NBYTES = DATA_W / 8;

    logic [DATA_W-1:0] ptr_d, ptr_q;
    logic [DATA_W-1:0] merged;
    logic              unused_bits;

    assign unused_bits = ^wdata_i[1:0];

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign merged[8*b +: 8] = (wr_i && be_i[b]) ? wdata_i[8*b +: 8]
                                                    : ptr_q[8*b +: 8];
    end

    always_comb begin
        ptr_d      = merged;
        ptr_d[1:0] = 2'b00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_word,
    input  logic [DATA_W/8-1:0] reg_be,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                seq_done,
    input  logic                seq_fault,
    output logic                dma_start,
    output logic [DATA_W-1:0]   dma_start_ptr,
    output logic                dma_abort,
    output logic                dma_irq,
    output logic                reg_acc_err
);

    localparam int            BE_W    = DATA_W / 8;
    localparam logic [BE_W-1:0] BE_CMD = BE_W'(1) << LANE_CMD;
    localparam logic [BE_W-1:0] BE_STS = BE_W'(1) << LANE_STS;

    logic              cmd_wr, sts_wr, ptr_wr, bad_wr, touches;
    logic              rise, fall;
    logic              aerr_d, aerr_q;
    logic [7:0]        cmd_byte, sts_byte;
    logic [DATA_W-1:0] ptr_val;
    logic [DATA_W-1:0] ctrl_word;

    // write decode
    always_comb begin
        touches = reg_be[LANE_CMD] || reg_be[LANE_STS];
        cmd_wr  = reg_wr && !reg_word && (reg_be == BE_CMD);
        sts_wr  = reg_wr && !reg_word && (reg_be == BE_STS);
        ptr_wr  = reg_wr && reg_word;
        bad_wr  = reg_wr && !reg_word && touches && !cmd_wr && !sts_wr;
        aerr_d  = bad_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aerr_q <= 1'b0;
        end else begin
            aerr_q <= aerr_d;
        end
    end

    bmdma_cmd_unit #(.PTR_W(DATA_W)) u_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (cmd_wr),
        .wbyte_i     (reg_wdata[8*LANE_CMD +: 8]),
        .done_i      (seq_done),
        .ptr_i       (ptr_val),
        .start_o     (dma_start),
        .abort_o     (dma_abort),
        .start_ptr_o (dma_start_ptr),
        .rise_o      (rise),
        .fall_o      (fall),
        .cmd_byte_o  (cmd_byte)
    );

    bmdma_sts_unit u_sts (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (sts_wr),
        .wbyte_i    (reg_wdata[8*LANE_STS +: 8]),
        .done_i     (seq_done),
        .fault_i    (seq_fault),
        .act_set_i  (rise),
        .act_clr_i  (fall),
        .sts_byte_o (sts_byte),
        .irq_o      (dma_irq)
    );

    bmdma_ptr_unit #(.DATA_W(DATA_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ptr_wr),
        .be_i    (reg_be),
        .wdata_i (reg_wdata),
        .ptr_o   (ptr_val)
    );

    // read path
    always_comb begin
        ctrl_word                     = '0;
        ctrl_word[8*LANE_CMD +: 8]    = cmd_byte;
        ctrl_word[8*LANE_STS +: 8]    = sts_byte;
        reg_rdata = reg_word ? ptr_val : ctrl_word;
    end

    assign reg_acc_err = aerr_q;

endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk (
    input logic clk,
    input logic rst_n,
    input logic seq_done,
    input logic seq_fault,
    input logic dma_start,
    input logic dma_abort,
    input logic dma_irq,
    input logic reg_acc_err,
    input logic run_b,
    input logic dir_b,
    input logic act_b,
    input logic err_b
);

    // R3: a start request coincides with a running, active channel
    a_r3_start_active: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> (act_b && run_b));

    // R4: an abort request leaves the channel stopped
    a_r4_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        dma_abort |-> (!act_b && !run_b));

    // R5: direction holds while running
    a_r5_dir_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        run_b |=> $stable(dir_b));

    // R6: active only ever appears together with the run bit
    a_r6_active_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        act_b |-> run_b);

    // R9: completion stops the channel and raises the interrupt
    a_r9_done_effect: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> (dma_irq && !act_b && !run_b));

    // R10: failure sets the error flag
    a_r10_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
        seq_fault |=> err_b);

    // R11: a rejected write issues no requests
    a_r11_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        reg_acc_err |-> (!dma_start && !dma_abort));

endmodule

bind bmdma_regs bmdma_regs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .seq_done    (seq_done),
    .seq_fault   (seq_fault),
    .dma_start   (dma_start),
    .dma_abort   (dma_abort),
    .dma_irq     (dma_irq),
    .reg_acc_err (reg_acc_err),
    .run_b       (cmd_byte[0]),
    .dir_b       (cmd_byte[3]),
    .act_b       (sts_byte[0]),
    .err_b       (sts_byte[1])
);

// File: tb/bmdma_regs_tb.sv
module bmdma_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_word = 1'b0;
    logic [3:0]  reg_be = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        seq_done = 1'b0;
    logic        seq_fault = 1'b0;
    logic        dma_start, dma_abort, dma_irq, reg_acc_err;
    logic [31:0] dma_start_ptr;

    int n_chk = 0;
    int n_fail = 0;

    logic        s_start, s_abort, s_err;
    logic [31:0] s_ptr;

    always #5 clk = ~clk;

    bmdma_regs u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_word(reg_word),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .seq_done(seq_done), .seq_fault(seq_fault), .dma_start(dma_start),
        .dma_start_ptr(dma_start_ptr), .dma_abort(dma_abort),
        .dma_irq(dma_irq), .reg_acc_err(reg_acc_err)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle: optional write, optional completion/failure; ends at negedge
    task automatic cyc(input logic w, input logic wd, input logic [3:0] be,
                       input logic [31:0] d, input logic dn, input logic fl);
        reg_wr    = w;
        reg_word  = wd;
        reg_be    = be;
        reg_wdata = d;
        seq_done  = dn;
        seq_fault = fl;
        @(negedge clk);
        reg_wr    = 1'b0;
        seq_done  = 1'b0;
        seq_fault = 1'b0;
        s_start   = dma_start;
        s_abort   = dma_abort;
        s_err     = reg_acc_err;
        s_ptr     = dma_start_ptr;
    endtask

    task automatic wcmd(input logic [7:0] v);
        cyc(1'b1, 1'b0, 4'b0001, {24'h0, v}, 1'b0, 1'b0);
    endtask

    task automatic wsts(input logic [7:0] v);
        cyc(1'b1, 1'b0, 4'b0100, {8'h0, v, 16'h0}, 1'b0, 1'b0);
    endtask

    task automatic rd(input logic wd, output logic [31:0] d);
        reg_word = wd;
        #1;
        d = reg_rdata;
    endtask

    task automatic rd_cmd(output logic [7:0] v);
        logic [31:0] d;
        rd(1'b0, d);
        v = d[7:0];
    endtask

    task automatic rd_sts(output logic [7:0] v);
        logic [31:0] d;
        rd(1'b0, d);
        v = d[23:16];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  b, b2;
        logic [31:0] ptr_now;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, d);
        check(d, 32'h0060_0000, "R1 control word after reset");
        rd(1'b1, d);
        check(d, 32'h0, "R1 pointer after reset");
        check({31'b0, dma_irq}, 32'h0, "R1 irq after reset");

        // R8 pointer: low bits forced, lanes independent
        cyc(1'b1, 1'b1, 4'b1111, 32'h1234_5677, 1'b0, 1'b0);
        rd(1'b1, d);
        check(d, 32'h1234_5674, "R8 full pointer write");
        cyc(1'b1, 1'b1, 4'b0010, 32'hAABB_CCDD, 1'b0, 1'b0);
        rd(1'b1, d);
        check(d, 32'h1234_CC74, "R8 single lane pointer write");
        cyc(1'b1, 1'b1, 4'b0001, 32'h0000_00FF, 1'b0, 1'b0);
        rd(1'b1, d);
        check(d, 32'h1234_CCFC, "R8 low byte forced bits");
        ptr_now = 32'h1234_CCFC;

        // R2 reserved lanes only: no effect, no error
        cyc(1'b1, 1'b0, 4'b1010, 32'hFFFF_FFFF, 1'b0, 1'b0);
        check({31'b0, s_err}, 32'h0, "R2 reserved lane write no error");
        rd(1'b0, d);
        check(d, 32'h0060_0000, "R2 reserved lanes read zero");

        // R11 every bad lane combination on word 0
        for (int be = 0; be < 16; be++) begin
            logic [3:0] bv;
            logic       expe;
            bv = 4'(be);
            if (bv == 4'b0001 || bv == 4'b0100) continue;
            expe = bv[0] || bv[2];
            cyc(1'b1, 1'b0, bv, 32'h0000_0009, 1'b0, 1'b0);
            check({31'b0, s_err}, {31'b0, expe}, "R11 access error flag");
            check({31'b0, s_start}, 32'h0, "R11 no start on bad write");
            rd(1'b0, d);
            check(d, 32'h0060_0000, "R11 registers unchanged");
            @(negedge clk);
            check({31'b0, reg_acc_err}, 32'h0, "R11 error lasts one cycle");
        end

        // R3 R4 R5 R13 command sweep from stopped and running states
        for (int pr = 0; pr < 2; pr++) begin
            for (int v = 0; v < 256; v++) begin
                logic [7:0] vv;
                logic       od, erun, edir;
                vv = 8'(v);
                od = ^vv;
                wcmd(8'h00);
                wcmd({4'b0, od, 3'b000});
                if (pr == 1) wcmd({4'b0, od, 3'b001});
                wcmd(vv);
                erun = vv[0];
                edir = (pr == 1) ? od : vv[3];
                check({31'b0, s_start}, {31'b0, (pr == 0) && vv[0]}, "R3 start pulse");
                check({31'b0, s_abort}, {31'b0, (pr == 1) && !vv[0]}, "R4 abort pulse");
                if ((pr == 0) && vv[0])
                    check(s_ptr, ptr_now, "R3 start carries pointer");
                rd_cmd(b);
                check({24'b0, b}, {24'b0, 4'b0, edir, 2'b0, erun}, "R5 R13 command readback");
                rd_sts(b2);
                check({31'b0, b2[0]}, {31'b0, erun}, "R3 R4 active bit");
            end
        end

        // R3 start pulse is one cycle wide, new pointer is used
        wcmd(8'h00);
        cyc(1'b1, 1'b1, 4'b1111, 32'hCAFE_0003, 1'b0, 1'b0);
        wcmd(8'h01);
        check(s_ptr, 32'hCAFE_0000, "R3 start pointer after update");
        @(negedge clk);
        check({31'b0, dma_start}, 32'h0, "R3 start one cycle");

        // R6 R7 R13 status sweep over all prior flag states
        for (int init = 0; init < 8; init++) begin
            for (int v = 0; v < 256; v++) begin
                logic [7:0] vv, exp;
                logic ia, ie, ii;
                vv = 8'(v);
                ia = init[0]; ie = init[1]; ii = init[2];
                wcmd(8'h00);
                wsts(8'h06);
                if (ii) cyc(1'b0, 1'b0, 4'b0, 32'h0, 1'b1, 1'b0);
                if (ie) cyc(1'b0, 1'b0, 4'b0, 32'h0, 1'b0, 1'b1);
                if (ia) wcmd(8'h01);
                wsts(vv);
                exp = {1'b0, vv[6], vv[5], 2'b00, ii && !vv[2], ie && !vv[1], ia};
                rd_sts(b);
                check({24'b0, b}, {24'b0, exp}, "R6 R7 R13 status readback");
                check({31'b0, dma_irq}, {31'b0, ii && !vv[2]}, "R7 irq follows flag");
            end
        end

        // R9 completion while running
        wcmd(8'h00);
        wsts(8'h66);
        wcmd(8'h09);
        cyc(1'b0, 1'b0, 4'b0, 32'h0, 1'b1, 1'b0);
        check({31'b0, s_abort}, 32'h0, "R9 completion gives no abort");
        rd_cmd(b);
        check({24'b0, b}, 32'h08, "R9 run bit cleared");
        rd_sts(b);
        check({24'b0, b}, 32'h64, "R9 active clear interrupt set");
        check({31'b0, dma_irq}, 32'h1, "R9 irq high");

        // R9 completion together with a start write
        wsts(8'h64);
        cyc(1'b1, 1'b0, 4'b0001, 32'h1, 1'b1, 1'b0);
        check({31'b0, s_start}, 32'h0, "R9 no start with completion");
        rd_cmd(b);
        check({24'b0, b}, 32'h0, "R9 run stays clear");

        // R12 completion beats interrupt clear
        wsts(8'h64);
        check({31'b0, dma_irq}, 32'h0, "R7 interrupt cleared");
        cyc(1'b1, 1'b0, 4'b0100, 32'h0064_0000, 1'b1, 1'b0);
        rd_sts(b);
        check({31'b0, b[2]}, 32'h1, "R12 interrupt stays set");

        // R10 R12 failure sets error and beats error clear
        wsts(8'h66);
        cyc(1'b0, 1'b0, 4'b0, 32'h0, 1'b0, 1'b1);
        rd_sts(b);
        check({31'b0, b[1]}, 32'h1, "R10 error set by failure");
        cyc(1'b1, 1'b0, 4'b0100, 32'h0062_0000, 1'b0, 1'b1);
        rd_sts(b);
        check({31'b0, b[1]}, 32'h1, "R12 error stays set");

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule